// File: doc/BRIEF.md
# AXI Burst Command Fragmenter

This block turns one DMA transfer request into a series of AXI4 address-channel commands. A request gives a starting byte address, a length in bytes and a cap on the beats allowed in one burst. The block issues bursts in address order. Each burst is as long as three limits allow: the programmed cap, the beats that remain in the transfer, and the beats left before the next 4 KB page boundary. No command ever crosses such a boundary.

The start address and the end address may fall anywhere inside a bus word. Each command's address is aligned to the bus width. Two byte-enable masks come with every command. One marks the lanes that carry transfer bytes on the burst's first beat, and the other does the same for its last beat. A data mover downstream uses these masks to write, or to drop, the partial words at the two ends of the transfer.

The block takes one request at a time. It raises a one-cycle done pulse after the final command of a request has been handshaken. A zero-length request also gives a done pulse, and it issues no command.

Top module: `axi_burst_fragmenter`

## Requirements
- R1: Every command address is aligned to the bus width (`BPB` = DATA_W/8 bytes). `cmd_size` equals log2(`BPB`).
- R2: Each burst has at most `req_max_len`+1 beats. Here `cmd_len` is the beat count minus one, and `req_max_len` ranges from 0 to 255, which gives 1 to 256 beats.
- R3: No burst crosses a 4 KB boundary: (cmd_addr mod 4096) + (cmd_len+1)·BPB ≤ 4096.
- R4: The first burst starts at the request address rounded down to a multiple of BPB. Each later burst starts right after the last beat of the burst before it. Each burst has min(cap, beats remaining to cover the end byte, beats left in the 4 KB page) beats.
- R5: Bit i of `cmd_first_be` is 1 exactly when byte `cmd_addr`+i lies in [start, start+length).
- R6: Bit i of `cmd_last_be` is 1 exactly when byte `cmd_addr`+`cmd_len`·BPB+i lies in [start, start+length).
- R7: `cmd_last` is 1 on the final burst of a request and 0 on all earlier bursts.
- R8: `req_ready` is 1 only while no command is pending. After a nonzero request is accepted, `cmd_valid` is 1 on the next cycle, and `req_ready` stays 0 until the cycle after the final command handshake.
- R9: A zero-length request produces no command. `done` is 1 in the cycle after it is accepted.
- R10: `done` is 1 for exactly the cycle after the final command handshake, and `cmd_valid` is 0 in that cycle.
- R11: While `cmd_valid` is 1 and `cmd_ready` is 0, all command outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | LEN_W | Transfer length in bytes |
| req_max_len | input | 8 | Burst cap, in beats minus one |
| cmd_valid | output | 1 | Address command valid |
| cmd_ready | input | 1 | Address command accepted |
| cmd_addr | output | ADDR_W | Bus-aligned burst address |
| cmd_len | output | 8 | Burst beats minus one |
| cmd_size | output | 3 | log2 of the bytes per beat |
| cmd_first_be | output | DATA_W/8 | Valid lanes on the burst's first beat |
| cmd_last_be | output | DATA_W/8 | Valid lanes on the burst's last beat |
| cmd_last | output | 1 | Final burst of the request |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The bench drives the splitter with several directed patterns, each chosen to show a different limit in charge of the burst length:
- An aligned short transfer, where the remaining length sets the burst.
- A long transfer with a small cap, where the programmed cap sets it.
- Transfers that straddle or end exactly at a 4 KB line, where the page boundary sets it.
- Transfers that begin and end inside one bus word, where both masks act on the same beat.

A zero-length request checks that done behaves correctly with no command. Seeded random addresses, lengths and caps then mix these limits in ways the directed cases do not reach. A randomly stalled `cmd_ready` checks that the command fields hold under backpressure. It also shows that advancing only on a handshake does not skip a burst or repeat one.

// File: rtl/frag_pkg.sv
package frag_pkg;

  typedef enum logic {ST_IDLE, ST_BUSY} frag_state_e;

  localparam int unsigned PAGE_BYTES = 4096;

  // Smaller of two 9-bit beat counts
  function automatic logic [8:0] beats_min(input logic [8:0] a, input logic [8:0] b);
    return (a < b) ? a : b;
  endfunction

  // Bytes from an offset inside a page up to the page end
  function automatic logic [12:0] page_room(input logic [11:0] page_off);
    return 13'd4096 - {1'b0, page_off};
  endfunction

endpackage

// File: rtl/frag_lane_mask.sv
module frag_lane_mask #(
  parameter int ADDR_W = 32,
  parameter int BPB    = 8
) (
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W:0]   hi_addr,
  output logic [BPB-1:0]    lane_en
);
  for (genvar i = 0; i < BPB; i++) begin : g_lane
    logic [ADDR_W:0] byte_a;
    assign byte_a     = {1'b0, beat_addr} + (ADDR_W+1)'(i);
    assign lane_en[i] = (byte_a >= {1'b0, lo_addr}) && (byte_a < hi_addr);
  end
endmodule

// File: rtl/frag_burst_calc.sv
module frag_burst_calc import frag_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int BPB    = 8,
  parameter int LG     = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W:0]   end_addr,
  input  logic [8:0]        max_beats,
  output logic [7:0]        burst_len,
  output logic              burst_last
);
  logic [ADDR_W:0] rem_bytes;
  logic [ADDR_W:0] rem_beats;
  logic [12:0]     page_beats;
  logic [8:0]      page_cap;
  logic [8:0]      cap_a;
  logic [8:0]      beats;

  always_comb begin
    rem_bytes  = end_addr - {1'b0, cur_addr};
    rem_beats  = (rem_bytes + (ADDR_W+1)'(BPB - 1)) >> LG;
    page_beats = page_room(cur_addr[11:0]) >> LG;
    page_cap   = (page_beats < 13'(max_beats)) ? page_beats[8:0] : max_beats;
    cap_a      = beats_min(page_cap, max_beats);
    beats      = (rem_beats < (ADDR_W+1)'(cap_a)) ? rem_beats[8:0] : cap_a;
    burst_last = ((ADDR_W+1)'(beats) == rem_beats);
    burst_len  = 8'(beats - 9'd1);
  end
endmodule

// File: rtl/frag_ctrl.sv
module frag_ctrl import frag_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int LG     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_bytes,
  input  logic [7:0]        req_max_len,
  output logic              req_ready,
  input  logic              cmd_ready,
  input  logic              burst_last,
  input  logic [7:0]        burst_len,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W:0]   end_addr,
  output logic [8:0]        max_beats,
  output logic              done
);
  frag_state_e state;
  logic        req_hs, cmd_hs, req_zero;
  logic [ADDR_W-1:0] step;

  assign req_ready = (state == ST_IDLE);
  assign cmd_valid = (state == ST_BUSY);
  assign req_hs    = req_valid && req_ready;
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign req_zero  = (req_bytes == '0);
  assign step      = ADDR_W'({1'b0, burst_len} + 9'd1) << LG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      start_addr <= '0;
      end_addr   <= '0;
      max_beats  <= 9'd1;
      done       <= 1'b0;
    end else begin
      done <= (req_hs && req_zero) || (cmd_hs && burst_last);
      if (req_hs && !req_zero) begin
        state      <= ST_BUSY;
        cur_addr   <= (req_addr >> LG) << LG;
        start_addr <= req_addr;
        end_addr   <= {1'b0, req_addr} + (ADDR_W+1)'(req_bytes);
        max_beats  <= {1'b0, req_max_len} + 9'd1;
      end else if (cmd_hs) begin
        if (burst_last) state <= ST_IDLE;
        else            cur_addr <= cur_addr + step;
      end
    end
  end

  // R11
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cur_addr));
  // R8
  start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_bytes != '0) |=> cmd_valid && !req_ready);
  // R9
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_bytes == '0) |=> done && !cmd_valid);
  // R10
  final_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && burst_last |=> done && !cmd_valid && req_ready);
endmodule

// File: rtl/axi_burst_fragmenter.sv
module axi_burst_fragmenter import frag_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int DATA_W = 64,
  localparam int BPB   = DATA_W / 8,
  localparam int LG    = $clog2(BPB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_bytes,
  input  logic [7:0]        req_max_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_len,
  output logic [2:0]        cmd_size,
  output logic [BPB-1:0]    cmd_first_be,
  output logic [BPB-1:0]    cmd_last_be,
  output logic              cmd_last,
  output logic              done
);
  logic [ADDR_W-1:0] cur_addr, start_addr, tail_addr;
  logic [ADDR_W:0]   end_addr;
  logic [8:0]        max_beats;
  logic [7:0]        burst_len;
  logic              burst_last;

  frag_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LG(LG)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_max_len(req_max_len), .req_ready(req_ready),
    .cmd_ready(cmd_ready), .burst_last(burst_last), .burst_len(burst_len),
    .cmd_valid(cmd_valid), .cur_addr(cur_addr), .start_addr(start_addr),
    .end_addr(end_addr), .max_beats(max_beats), .done(done)
  );

  frag_burst_calc #(.ADDR_W(ADDR_W), .BPB(BPB), .LG(LG)) i_calc (
    .cur_addr(cur_addr), .end_addr(end_addr), .max_beats(max_beats),
    .burst_len(burst_len), .burst_last(burst_last)
  );

  assign tail_addr = cur_addr + (ADDR_W'(burst_len) << LG);

  frag_lane_mask #(.ADDR_W(ADDR_W), .BPB(BPB)) i_head_mask (
    .beat_addr(cur_addr), .lo_addr(start_addr), .hi_addr(end_addr),
    .lane_en(cmd_first_be)
  );

  frag_lane_mask #(.ADDR_W(ADDR_W), .BPB(BPB)) i_tail_mask (
    .beat_addr(tail_addr), .lo_addr(start_addr), .hi_addr(end_addr),
    .lane_en(cmd_last_be)
  );

  assign cmd_addr = cur_addr;
  assign cmd_len  = burst_len;
  assign cmd_size = 3'(LG);
  assign cmd_last = burst_last;

  // R3
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ({2'b0, cmd_addr[11:0]} + ((14'(cmd_len) + 14'd1) << LG)) <= 14'd4096);
  // R2
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ({1'b0, cmd_len} + 9'd1) <= max_beats);
  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr[LG-1:0] == '0);
  // R5
  head_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_first_be != '0 && cmd_last_be != '0);
endmodule

// File: tb/test_axi_burst_fragmenter.sv
module test_axi_burst_fragmenter;
  localparam int CLK_PERIOD = 10;
  localparam int BPB = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cmd_ready = 0;
  logic req_ready, cmd_valid, cmd_last, done;
  logic [31:0] req_addr = 0, cmd_addr;
  logic [23:0] req_bytes = 0;
  logic [7:0]  req_max_len = 0, cmd_len;
  logic [2:0]  cmd_size;
  logic [7:0]  cmd_first_be, cmd_last_be;

  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_burst_fragmenter i_axi_burst_fragmenter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_max_len(req_max_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_first_be(cmd_first_be),
    .cmd_last_be(cmd_last_be), .cmd_last(cmd_last), .done(done)
  );

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic longint exp_beats(longint cur, longint en, longint cap);
    longint rem, page, b;
    rem  = (en - cur + BPB - 1) / BPB;
    page = (4096 - (cur % 4096)) / BPB;
    b = cap;
    if (page < b) b = page;
    if (rem < b) b = rem;
    return b;
  endfunction

  function automatic logic [7:0] exp_mask(longint beat, longint s, longint e);
    logic [7:0] m;
    for (int i = 0; i < BPB; i++) m[i] = (beat + i >= s) && (beat + i < e);
    return m;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_xfer(input longint a, input longint n, input int ml);
    longint cur, en, b, rem;
    logic [31:0] h_addr; logic [7:0] h_len, h_fb, h_lb; logic h_last;
    bit rdy;
    @(negedge clk);
    check(req_ready === 1'b1, "R8 idle ready", req_ready, 1);
    req_valid = 1; req_addr = 32'(a); req_bytes = 24'(n); req_max_len = 8'(ml);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (n == 0) begin
      check(done === 1'b1 && cmd_valid === 1'b0, "R9 zero-length done", {done, cmd_valid}, 2'b10);
      @(negedge clk);
      check(done === 1'b0, "R10 done single cycle", done, 0);
      return;
    end
    cur = a - (a % BPB); en = a + n;
    forever begin
      rdy = ($urandom % 4) != 0;
      cmd_ready = rdy;
      check(cmd_valid === 1'b1 && req_ready === 1'b0, "R8 busy", {cmd_valid, req_ready}, 2'b10);
      if (rdy) begin
        b = exp_beats(cur, en, ml + 1);
        rem = (en - cur + BPB - 1) / BPB;
        check(cmd_addr == 32'(cur), "R4 burst address", cmd_addr, cur);
        check(cmd_addr[2:0] == 0 && cmd_size == 3'd3, "R1 align/size", cmd_size, 3);
        check(cmd_len == 8'(b - 1), "R4 burst length", cmd_len, b - 1);
        check(cmd_len <= 8'(ml), "R2 cap", cmd_len, ml);
        check((cur % 4096) + (longint'(cmd_len) + 1) * BPB <= 4096, "R3 page", cmd_len, b - 1);
        check(cmd_first_be == exp_mask(cur, a, en), "R5 first lanes", cmd_first_be, exp_mask(cur, a, en));
        check(cmd_last_be == exp_mask(cur + (b - 1) * BPB, a, en), "R6 last lanes", cmd_last_be,
              exp_mask(cur + (b - 1) * BPB, a, en));
        check(cmd_last == (b == rem), "R7 last flag", cmd_last, b == rem);
        @(posedge clk);
        @(negedge clk);
        if (b == rem) begin
          cmd_ready = 0;
          check(done === 1'b1 && cmd_valid === 1'b0 && req_ready === 1'b1, "R10 done after last",
                {done, cmd_valid, req_ready}, 3'b101);
          return;
        end
        cur = cur + b * BPB;
      end else begin
        h_addr = cmd_addr; h_len = cmd_len; h_fb = cmd_first_be; h_lb = cmd_last_be; h_last = cmd_last;
        @(posedge clk);
        @(negedge clk);
        check(cmd_valid && cmd_addr == h_addr && cmd_len == h_len && cmd_first_be == h_fb &&
              cmd_last_be == h_lb && cmd_last == h_last, "R11 hold under stall", cmd_addr, h_addr);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd12345));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R8 reset state",
          {req_ready, cmd_valid, done}, 3'b100);
    rst_n = 1;
    run_xfer(64'h1000, 64, 255);          // aligned, length limits
    run_xfer(64'h2003, 100, 3);           // unaligned start and end, cap limits
    run_xfer(64'h0FF0, 40, 255);          // straddles 4 KB
    run_xfer(64'h1F00, 256, 255);         // ends exactly on 4 KB line
    run_xfer(64'h3003, 2, 10);            // one beat, both masks on same word
    run_xfer(64'h4000, 0, 7);             // zero length
    run_xfer(64'h5005, 9000, 255);        // long, several pages, max cap
    run_xfer(64'h6001, 50, 0);            // one beat per burst
    for (int k = 0; k < 40; k++)
      run_xfer(longint'($urandom & 32'h7FFF_FFFF), longint'($urandom % 5000), int'($urandom % 256));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule